// File: doc/BRIEF.md
# Start Trigger Selector and Conditioner

This block decides when a waveform playback engine begins. It picks one start source from twelve external trigger lines, a software strobe, or an immediate setting that needs no trigger at all. External lines are synchronised to the system clock. A rising edge counts as a trigger only if the line then stays high for a minimum number of clock samples. When the unit is armed, the first accepted trigger produces a single-cycle start event.

Each accepted trigger, whether it came from a line or from software, can also be sent out again. After a fixed delay it appears as a stretched pulse on one of nine export lines. Two of these are front-panel lines and seven are backplane lines.

The source code is captured while the unit is disarmed and is frozen while it is armed. Each arming produces at most one start event. The unit must be disarmed and armed again before it can fire again.

Top module: `start_trig_cond`

## Requirements
- R1: While reset is active, `start_o` and `exp_o` are low and the captured source is immediate. If `arm` is already high on the first clock edge after reset is released, the source is not reloaded. A start event then follows at once, whatever `src_sel` holds.
- R2: With source code 0 (immediate), `start_o` is high for exactly one cycle, in the cycle after the first clock edge at which `arm` is sampled high.
- R3: With source code 1 (software), a one-cycle `sw_trig` pulse while armed gives exactly one `start_o` cycle, one clock edge after the strobe is sampled.
- R4: Source codes 2 to 13 select trigger line `trig_in[code-2]`. Lines 0–1 are front panel, 2–9 are backplane 0–7, 10 is the star line and 11 is a spare line. Edges on lines that are not selected, and codes 14 and 15, never give a start.
- R5: An external trigger is accepted only after 3 consecutive high samples taken after the two-flop synchroniser. `start_o` rises 5 clock edges after the line is first sampled high. A pulse of 2 samples is rejected, and any low sample restarts the count.
- R6: Only a rising edge triggers. A line that is already high when the unit is armed does not produce a start until it has gone low and risen again.
- R7: At most one start event occurs per arming. Further triggers are ignored until `arm` falls and rises again.
- R8: `src_sel` is captured only while `arm` is low. Changes to it while armed have no effect.
- R9: An accepted line or software trigger drives the export output 6 cycles after `start_o` rises, for exactly 16 cycles. It drives only `exp_o[exp_dst]` for codes 0–8: 0–1 are front-panel lines and 2–8 are backplane lines 0–6. Codes 9–15, or `exp_en` low, drive no line. The immediate source exports nothing.
- R10: While an export pulse is being delayed or stretched, line and software triggers are not accepted, even after re-arming.
- R11: Triggers that arrive while `arm` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Level; high lets one start event occur |
| trig_in | input | 12 | Asynchronous external trigger lines |
| src_sel | input | 4 | Start source code (0 immediate, 1 software, 2–13 line) |
| sw_trig | input | 1 | Software trigger strobe |
| exp_en | input | 1 | Enables the exported trigger pulse |
| exp_dst | input | 4 | Export destination code |
| start_o | output | 1 | Single-cycle start event |
| exp_o | output | 9 | Exported trigger pulse, one line at a time |

## Verification
External lines are driven with pulses of 2, 3 and 4 samples, with a split pulse (2 high, 1 low, 2 high), and with a level already high before arming. Together these separate the width filter from plain edge detection and show that the counter restarts on a low sample. Pulses on the wrong line, and on several source codes that include the star and spare lines, confirm the line mapping. Software strobes are sent while disarmed, while armed, while an export is still in flight and after a source change made while armed. These cases separate the arm, busy and source-capture rules. Export timing and width are measured from each observed start and checked for several destination codes and with export disabled.

// File: rtl/start_trig_cond.sv
module start_trig_cond #(
  parameter int N_LINES     = 12,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 3,
  parameter int EXP_DELAY   = 6,
  parameter int EXP_WIDTH   = 16,
  parameter int N_DEST      = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [N_LINES-1:0] trig_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               sw_trig,
  input  logic               exp_en,
  input  logic [SEL_W-1:0]   exp_dst,
  output logic               start_o,
  output logic [N_DEST-1:0]  exp_o
);

  localparam logic [SEL_W-1:0] SRC_IMM   = SEL_W'(0);
  localparam logic [SEL_W-1:0] SRC_SW    = SEL_W'(1);
  localparam logic [SEL_W-1:0] SRC_LINE0 = SEL_W'(2);
  localparam int CNT_W = $clog2(MIN_HIGH + 1);
  localparam int ST_W  = $clog2(EXP_WIDTH + 1);

  logic [SYNC_STAGES-1:0][N_LINES-1:0] sync_q;
  logic [N_LINES-1:0] trig_s;
  logic [SEL_W-1:0]   src_q;
  logic [SEL_W-1:0]   line_idx;
  logic               line_ok;
  logic               sel_lvl;
  logic               src_chg;
  logic [CNT_W-1:0]   hi_cnt;
  logic               edge_ok;
  logic               fired_q;
  logic [EXP_DELAY-1:0] dly_q;
  logic [ST_W-1:0]    st_cnt;
  logic               busy;
  logic               exp_active;
  logic               take_imm;
  logic               take_trg;
  logic               take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};

  assign trig_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    src_q <= SRC_IMM;
    else if (!arm) src_q <= src_sel;

  assign src_chg  = !arm && (src_sel != src_q);
  assign line_idx = src_q - SRC_LINE0;
  assign line_ok  = (src_q >= SRC_LINE0) && (32'(line_idx) < N_LINES);

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < N_LINES; i++)
      if (line_ok && 32'(line_idx) == i && trig_s[i]) sel_lvl = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          hi_cnt <= '0;
    else if (src_chg || !sel_lvl)        hi_cnt <= '0;
    else if (hi_cnt != CNT_W'(MIN_HIGH)) hi_cnt <= hi_cnt + 1'b1;

  assign edge_ok = sel_lvl && !src_chg && (hi_cnt == CNT_W'(MIN_HIGH - 1));

  assign busy       = (|dly_q) || (st_cnt != '0);
  assign exp_active = (st_cnt != '0);

  assign take_imm = arm && !fired_q && (src_q == SRC_IMM);
  assign take_trg = arm && !fired_q && !busy &&
                    (((src_q == SRC_SW) && sw_trig) || (line_ok && edge_ok));
  assign take     = take_imm || take_trg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    fired_q <= 1'b0;
    else if (!arm) fired_q <= 1'b0;
    else if (take) fired_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) start_o <= 1'b0;
    else        start_o <= take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly_q <= '0;
    else        dly_q <= {dly_q[EXP_DELAY-2:0], take_trg};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   st_cnt <= '0;
    else if (dly_q[EXP_DELAY-1])  st_cnt <= ST_W'(EXP_WIDTH);
    else if (st_cnt != '0)        st_cnt <= st_cnt - 1'b1;

  always_comb
    for (int d = 0; d < N_DEST; d++)
      exp_o[d] = exp_active && exp_en && (32'(exp_dst) == d);

  // R7: a start event never lasts more than one cycle
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R11: a start needs arm sampled high at the edge that produced it
  p_start_needs_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(arm));

  // R9: at most one export line at a time
  p_exp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exp_o));

  // R9: the export stretch begins only from the end of the delay line
  p_exp_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_active) |-> $past(dly_q[EXP_DELAY-1]));

  // R10: a triggered start is never taken while an export is in flight
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && src_q != SRC_IMM) |-> $past(!busy));

  // R8: the captured source holds while armed
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && $past(arm)) |-> $stable(src_q));

endmodule

// File: tb/test_start_trig_cond.sv
module test_start_trig_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [11:0] trig_in = '0;
  logic [3:0]  src_sel = '0;
  logic        sw_trig = 1'b0;
  logic        exp_en = 1'b0;
  logic [3:0]  exp_dst = '0;
  logic        start_o;
  logic [8:0]  exp_o;

  int checks = 0;
  int fails = 0;
  int n_start, first_start, n_exp, first_exp;
  logic [8:0] exp_seen;

  always #4 clk = ~clk;

  start_trig_cond i_start_trig_cond (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_in(trig_in), .src_sel(src_sel),
    .sw_trig(sw_trig), .exp_en(exp_en), .exp_dst(exp_dst),
    .start_o(start_o), .exp_o(exp_o));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe(input int n);
    n_start = 0; first_start = -1; n_exp = 0; first_exp = -1; exp_seen = '0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (start_o) begin
        n_start++;
        if (first_start < 0) first_start = i;
      end
      if (|exp_o) begin
        n_exp++;
        if (first_exp < 0) first_exp = i;
        exp_seen |= exp_o;
      end
    end
  endtask

  task automatic pulse(input int line, input int w);
    trig_in[line] = 1'b1;
    repeat (w) @(negedge clk);
    trig_in[line] = 1'b0;
  endtask

  task automatic strobe();
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic rearm(input logic [3:0] src);
    arm = 1'b0;
    src_sel = src;
    repeat (3) @(negedge clk);
    arm = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    src_sel = 4'd1; arm = 1'b1;
    repeat (3) @(negedge clk);
    check(start_o == 1'b0, "R1", "start during reset", start_o, 0);
    check(exp_o == '0, "R1", "export during reset", exp_o, 0);
    rst_n = 1'b1;
    observe(10);
    check(n_start == 1 && first_start == 1, "R1", "immediate default start index",
          first_start, 1);
    arm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_immediate();
    src_sel = 4'd0;
    repeat (3) @(negedge clk);
    arm = 1'b1;
    observe(30);
    check(n_start == 1, "R2", "immediate start count", n_start, 1);
    check(first_start == 1, "R2", "immediate start index", first_start, 1);
    check(n_exp == 0, "R9", "immediate exports nothing", n_exp, 0);
    observe(20);
    check(n_start == 0, "R7", "no second start while armed", n_start, 0);
    arm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_software();
    src_sel = 4'd1; exp_en = 1'b1; exp_dst = 4'd2;
    repeat (3) @(negedge clk);
    fork strobe(); observe(10); join
    check(n_start == 0, "R11", "strobe while disarmed", n_start, 0);
    arm = 1'b1;
    observe(5);
    check(n_start == 0, "R3", "software waits for strobe", n_start, 0);
    fork strobe(); observe(30); join
    check(n_start == 1 && first_start == 1, "R3", "software start index", first_start, 1);
    check(first_exp == 7, "R9", "export delay after strobe", first_exp, 7);
    check(n_exp == 16, "R9", "export width", n_exp, 16);
    check(exp_seen == 9'b000000100, "R9", "export line dst 2", exp_seen, 4);
    fork strobe(); observe(30); join
    check(n_start == 0, "R7", "second strobe same arming", n_start, 0);
  endtask

  task automatic t_extern();
    exp_dst = 4'd0;
    rearm(4'd7);
    fork pulse(4, 5); observe(30); join
    check(n_start == 0, "R4", "unselected line ignored", n_start, 0);
    fork pulse(5, 3); observe(40); join
    check(n_start == 1, "R5", "3-sample pulse accepted", n_start, 1);
    check(first_start == 5, "R5", "external start latency", first_start, 5);
    check(first_exp == 11, "R9", "external export delay", first_exp, 11);
    check(n_exp == 16 && exp_seen == 9'b1, "R9", "export dst 0 width", n_exp, 16);
    foreach (exp_seen[k]) ;
    for (int c = 2; c <= 13; c += 11) begin
      rearm(4'(c));
      fork pulse(c - 2, 3); observe(40); join
      check(n_start == 1 && first_start == 5, "R4", $sformatf("code %0d line", c),
            first_start, 5);
    end
    rearm(4'd12);
    fork pulse(10, 4); observe(40); join
    check(n_start == 1, "R4", "star line code 12", n_start, 1);
    rearm(4'd14);
    trig_in = '1;
    repeat (6) @(negedge clk);
    trig_in = '0;
    observe(30);
    check(n_start == 0, "R4", "code 14 selects nothing", n_start, 0);
  endtask

  task automatic t_width();
    rearm(4'd7);
    fork pulse(5, 2); observe(30); join
    check(n_start == 0, "R5", "2-sample pulse rejected", n_start, 0);
    fork
      begin pulse(5, 2); @(negedge clk); pulse(5, 2); end
      observe(30);
    join
    check(n_start == 0, "R5", "split pulse rejected", n_start, 0);
    fork pulse(5, 4); observe(40); join
    check(n_start == 1, "R5", "4-sample pulse accepted", n_start, 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_level();
    arm = 1'b0; src_sel = 4'd7;
    trig_in[5] = 1'b1;
    repeat (10) @(negedge clk);
    arm = 1'b1;
    observe(20);
    check(n_start == 0, "R6", "high level at arm", n_start, 0);
    trig_in[5] = 1'b0;
    repeat (3) @(negedge clk);
    fork pulse(5, 3); observe(40); join
    check(n_start == 1, "R6", "fresh rising edge", n_start, 1);
  endtask

  task automatic t_lock();
    rearm(4'd7);
    src_sel = 4'd1;
    fork strobe(); observe(20); join
    check(n_start == 0, "R8", "source change while armed", n_start, 0);
    fork pulse(5, 3); observe(40); join
    check(n_start == 1, "R8", "old source still active", n_start, 1);
  endtask

  task automatic t_busy();
    exp_dst = 4'd8;
    rearm(4'd1);
    fork strobe(); observe(3); join
    check(n_start == 1, "R10", "first strobe", n_start, 1);
    arm = 1'b0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    fork strobe(); observe(30); join
    check(n_start == 0, "R10", "strobe during export", n_start, 0);
    check(exp_seen == 9'h100, "R9", "export dst 8", exp_seen, 256);
    fork strobe(); observe(30); join
    check(n_start == 1, "R10", "strobe after export", n_start, 1);
  endtask

  task automatic t_no_export();
    exp_dst = 4'd12;
    rearm(4'd1);
    fork strobe(); observe(30); join
    check(n_start == 1 && n_exp == 0, "R9", "dst 12 drives nothing", n_exp, 0);
    exp_dst = 4'd3; exp_en = 1'b0;
    rearm(4'd1);
    fork strobe(); observe(30); join
    check(n_start == 1 && n_exp == 0, "R9", "export disabled", n_exp, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_immediate();
    t_software();
    repeat (30) @(negedge clk);
    t_extern();
    t_width();
    t_level();
    repeat (30) @(negedge clk);
    t_lock();
    repeat (30) @(negedge clk);
    t_busy();
    repeat (30) @(negedge clk);
    t_no_export();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule